// File: doc/BRIEF.md
# Caption Byte Capture with Line Select

This block sits behind a video data slicer and pulls the two caption characters off one chosen line of each field. The slicer supplies a sliced data bit together with a strobe at the centre of each bit cell. The system supplies the current line number plus pulses at the start and at the end of every line. On the selected line, the block searches the bit stream for the start pattern that follows the clock run-in. It then shifts in sixteen data bits, least significant bit first, as two characters.

At the end of the selected line, a complete packet is moved into two holding registers. Each register has a flag that marks an odd-parity violation. A new-data flag is raised, and the flag clears when the CPU reads the second register. The interrupt fires at every end of the selected line, even when nothing valid arrived. A sticky pending bit keeps the event until it is acknowledged. Checking parity at the command level and decoding characters are left to software.

Top module: `cc_byte_capture`

## Requirements
- R1: Bits are taken only on a line whose number, sampled at `line_start_i`, equals the effective selected line; strobes on any other line have no effect on data, flags or interrupt.
- R2: A `line_sel_i` value from 17 to 23 selects that line; any other value selects line 21.
- R3: Capture begins only after the 3-bit pattern 0,0,1 (in arrival order) is matched within the window; bits before the match, including the run-in, are not stored.
- R4: The 16 bits after the match are taken LSB first; bits 1 to 8 form `data1_o` and bits 9 to 16 form `data2_o`; strobes after the 16th bit in the same line are ignored.
- R5: Each byte has its own parity-error flag, set when its 8 bits (bit 7 being parity) hold an even number of ones, updated only when the byte is loaded.
- R6: `new_data_o` is set at line end only when all 16 bits were received; a pulse on `rd_data2_i` clears it.
- R7: `irq_o` is a one-cycle pulse in the cycle after `line_end_i` on the selected line, whether or not data was received, and never on other lines.
- R8: `irq_pend_o` is set together with `irq_o` and stays set until `irq_ack_i`.
- R9: If the packet is incomplete at line end, both data registers and parity flags keep their previous values.
- R10: After reset, data, flags, interrupt and pending are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_num_i | input | LINE_W | Current video line number |
| line_sel_i | input | LINE_W | Programmed capture line |
| line_start_i | input | 1 | Pulse at line start |
| line_end_i | input | 1 | Pulse at line end |
| bit_i | input | 1 | Sliced data bit |
| bit_stb_i | input | 1 | Bit-centre strobe |
| rd_data2_i | input | 1 | CPU read of second data register |
| irq_ack_i | input | 1 | Clears pending interrupt |
| data1_o | output | 8 | First character |
| data2_o | output | 8 | Second character |
| par_err1_o | output | 1 | Parity error, first character |
| par_err2_o | output | 1 | Parity error, second character |
| new_data_o | output | 1 | Complete packet loaded, not yet read |
| irq_o | output | 1 | End-of-selected-line pulse |
| irq_pend_o | output | 1 | Sticky interrupt pending |

## Verification
The in-line assertions check the following properties on every cycle: the interrupt lasts exactly one cycle and always sets the pending bit, the pending bit holds until acknowledged, the data registers stay stable unless a full packet is loaded, the bit counter never passes sixteen, and the window opens only at a line start. The directed scenarios cover the rest: line clamping at the range edges and outside them, rejection of bits before the start pattern, LSB-first byte order, the parity flag values, and the kept contents after a short packet. These properties need chosen stimulus and expected data values.

// File: rtl/cc_cap_pkg.sv
package cc_cap_pkg;
  localparam int BYTE_W = 8;
  localparam int NBYTES = 2;
  localparam int PKT_W  = BYTE_W * NBYTES;
  localparam int CNT_W  = $clog2(PKT_W + 1);
  typedef enum logic [1:0] {ST_HUNT, ST_DATA, ST_DONE} cap_st_e;
endpackage

// File: rtl/cc_line_gate.sv
module cc_line_gate #(
  parameter int LINE_W   = 9,
  parameter int LINE_MIN = 17,
  parameter int LINE_MAX = 23,
  parameter int LINE_DEF = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic [LINE_W-1:0] line_sel_i,
  input  logic              line_start_i,
  input  logic              line_end_i,
  output logic              win_o
);
  logic [LINE_W-1:0] eff_line;
  logic              sel_ok;

  assign sel_ok   = (line_sel_i >= LINE_W'(LINE_MIN)) && (line_sel_i <= LINE_W'(LINE_MAX));
  assign eff_line = sel_ok ? line_sel_i : LINE_W'(LINE_DEF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           win_o <= 1'b0;
    else if (line_end_i)   win_o <= 1'b0;
    else if (line_start_i) win_o <= (line_num_i == eff_line);
  end

  // R1: window opens only on a line start
  a_r1_win_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(win_o) |-> $past(line_start_i));
endmodule

// File: rtl/cc_bit_shifter.sv
module cc_bit_shifter
  import cc_cap_pkg::*;
#(
  parameter int          START_W   = 3,
  parameter logic [2:0]  START_PAT = 3'b001
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_i,
  input  logic             line_start_i,
  input  logic             bit_i,
  input  logic             bit_stb_i,
  output logic [PKT_W-1:0] pkt_o,
  output logic             full_o
);
  cap_st_e            st_q;
  logic [START_W-1:0] hist_q, hist_nx;
  logic [CNT_W-1:0]   cnt_q;
  logic               take;

  assign take    = win_i && bit_stb_i;
  assign hist_nx = {hist_q[START_W-2:0], bit_i};
  assign full_o  = (st_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      hist_q <= '1;
      cnt_q  <= '0;
      pkt_o  <= '0;
    end else if (line_start_i) begin
      st_q   <= ST_HUNT;
      hist_q <= '1;
      cnt_q  <= '0;
    end else if (take) begin
      unique case (st_q)
        ST_HUNT: begin
          hist_q <= hist_nx;
          if (hist_nx == START_PAT) begin
            st_q  <= ST_DATA;
            cnt_q <= '0;
          end
        end
        ST_DATA: begin
          pkt_o <= {bit_i, pkt_o[PKT_W-1:1]};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(PKT_W - 1)) st_q <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  // R4: never more than PKT_W data bits
  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(PKT_W));
  // R3: done is reachable only through the data phase
  a_r3_no_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HUNT) |=> (st_q != ST_DONE));
endmodule

// File: rtl/cc_hold_regs.sv
module cc_hold_regs
  import cc_cap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_end_i,
  input  logic              win_i,
  input  logic              full_i,
  input  logic [PKT_W-1:0]  pkt_i,
  input  logic              rd_data2_i,
  input  logic              irq_ack_i,
  output logic [BYTE_W-1:0] data_o [NBYTES],
  output logic [NBYTES-1:0] perr_o,
  output logic              new_o,
  output logic              irq_o,
  output logic              pend_o
);
  logic fire, load;

  assign fire = line_end_i && win_i;
  assign load = fire && full_i;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[g] <= '0;
        perr_o[g] <= 1'b0;
      end else if (load) begin
        data_o[g] <= pkt_i[g*BYTE_W +: BYTE_W];
        perr_o[g] <= ~^pkt_i[g*BYTE_W +: BYTE_W];
      end
    end
    // R9: registers hold unless a full packet is loaded
    a_r9_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load |=> $stable(data_o[g]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      new_o  <= 1'b0;
      irq_o  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      irq_o <= fire;
      if (load)            new_o <= 1'b1;
      else if (rd_data2_i) new_o <= 1'b0;
      if (fire)            pend_o <= 1'b1;
      else if (irq_ack_i)  pend_o <= 1'b0;
    end
  end

  a_r7_irq_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r8_irq_sets_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_o);
  a_r8_pend_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !irq_ack_i) |=> pend_o);
  a_r6_new_with_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(new_o) |-> irq_o);
endmodule

// File: rtl/cc_byte_capture.sv
module cc_byte_capture
  import cc_cap_pkg::*;
#(
  parameter int LINE_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic [LINE_W-1:0] line_sel_i,
  input  logic              line_start_i,
  input  logic              line_end_i,
  input  logic              bit_i,
  input  logic              bit_stb_i,
  input  logic              rd_data2_i,
  input  logic              irq_ack_i,
  output logic [7:0]        data1_o,
  output logic [7:0]        data2_o,
  output logic              par_err1_o,
  output logic              par_err2_o,
  output logic              new_data_o,
  output logic              irq_o,
  output logic              irq_pend_o
);
  logic              win;
  logic              full;
  logic [PKT_W-1:0]  pkt;
  logic [BYTE_W-1:0] data [NBYTES];
  logic [NBYTES-1:0] perr;

  cc_line_gate #(.LINE_W(LINE_W)) u_gate (
    .clk_i, .rst_ni, .line_num_i, .line_sel_i, .line_start_i, .line_end_i,
    .win_o(win)
  );

  cc_bit_shifter u_shift (
    .clk_i, .rst_ni, .win_i(win), .line_start_i, .bit_i, .bit_stb_i,
    .pkt_o(pkt), .full_o(full)
  );

  cc_hold_regs u_hold (
    .clk_i, .rst_ni, .line_end_i, .win_i(win), .full_i(full), .pkt_i(pkt),
    .rd_data2_i, .irq_ack_i,
    .data_o(data), .perr_o(perr), .new_o(new_data_o), .irq_o(irq_o), .pend_o(irq_pend_o)
  );

  assign data1_o    = data[0];
  assign data2_o    = data[1];
  assign par_err1_o = perr[0];
  assign par_err2_o = perr[1];
endmodule

// File: tb/cc_byte_capture_bench.sv
module cc_byte_capture_bench;
  logic       clk = 0, rst_n = 0;
  logic [8:0] line_num = 0, line_sel = 21;
  logic       line_start = 0, line_end = 0, bit_d = 0, bit_stb = 0, rd2 = 0, ack = 0;
  logic [7:0] d1, d2;
  logic       pe1, pe2, nd, irq, pend;
  int         n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  cc_byte_capture u_cc_byte_capture (
    .clk_i(clk), .rst_ni(rst_n), .line_num_i(line_num), .line_sel_i(line_sel),
    .line_start_i(line_start), .line_end_i(line_end), .bit_i(bit_d), .bit_stb_i(bit_stb),
    .rd_data2_i(rd2), .irq_ack_i(ack), .data1_o(d1), .data2_o(d2),
    .par_err1_o(pe1), .par_err2_o(pe2), .new_data_o(nd), .irq_o(irq), .irq_pend_o(pend)
  );

  task automatic ck(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ck_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    ck(act === exp, req, act, exp);
  endtask

  // run-in 1,0,1,0 then start 0,0,1 then byte1, byte2 (all LSB first)
  function automatic logic [31:0] mk_pkt(input logic [7:0] b1, input logic [7:0] b2);
    return {9'h0, b2, b1, 3'b100, 4'b0101};
  endfunction

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  // one full line; returns irq seen in cycle after line end, and in the cycle after that
  task automatic run_line(input int num, input logic [31:0] w, input int nbits,
                          output logic irq_a, output logic irq_b);
    @(negedge clk); line_num = 9'(num); line_start = 1;
    @(negedge clk); line_start = 0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); bit_d = w[i]; bit_stb = 1;
      @(negedge clk); bit_stb = 0;
    end
    @(negedge clk); line_end = 1;
    @(posedge clk); #1 irq_a = irq;
    @(negedge clk); line_end = 0;
    @(posedge clk); #1 irq_b = irq;
  endtask

  task automatic t_reset();
    ck_eq("R10 data1", d1, 0); ck_eq("R10 data2", d2, 0);
    ck_eq("R10 flags", {pe1, pe2, nd, irq, pend}, 0);
  endtask

  task automatic t_basic();
    logic a, b;
    line_sel = 21;
    run_line(21, mk_pkt(8'hC1, 8'h80), 23, a, b);
    ck_eq("R4 data1", d1, 8'hC1); ck_eq("R4 data2", d2, 8'h80);
    ck_eq("R5 odd ok", {pe1, pe2}, 0);
    ck_eq("R6 new set", nd, 1);
    ck_eq("R7 irq pulse", {a, b}, 2'b10);
    ck_eq("R8 pend set", pend, 1);
    @(negedge clk); #20;
    ck_eq("R8 pend holds", pend, 1);
    pulse(rd2); #1 ck_eq("R6 new cleared", nd, 0);
    pulse(ack); #1 ck_eq("R8 pend cleared", pend, 0);
  endtask

  task automatic t_parity();
    logic a, b;
    run_line(21, mk_pkt(8'h03, 8'h07), 23, a, b);
    ck_eq("R5 perr flags", {pe1, pe2}, 2'b10);
    ck_eq("R4 data pair", {d1, d2}, 16'h0307);
    pulse(rd2); pulse(ack);
  endtask

  task automatic t_short();
    logic a, b;
    run_line(21, mk_pkt(8'hFF, 8'hFF), 17, a, b);
    ck_eq("R7 irq without data", {a, b}, 2'b10);
    ck_eq("R9 data kept", {d1, d2}, 16'h0307);
    ck_eq("R9 perr kept", {pe1, pe2}, 2'b10);
    ck_eq("R6 no new on short", nd, 0);
    pulse(ack);
  endtask

  task automatic t_other_line();
    logic a, b;
    run_line(20, mk_pkt(8'h15, 8'h2A), 23, a, b);
    ck_eq("R1 no irq other line", {a, b, pend}, 0);
    ck_eq("R1 data untouched", {d1, d2, nd}, {16'h0307, 1'b0});
  endtask

  task automatic t_clamp();
    logic a, b;
    line_sel = 30;
    run_line(21, mk_pkt(8'h15, 8'h2A), 23, a, b);
    ck_eq("R2 clamp to 21", {d1, d2, a}, {16'h152A, 1'b1});
    pulse(rd2); pulse(ack);
    run_line(30, mk_pkt(8'h8F, 8'h8F), 23, a, b);
    ck_eq("R2 line 30 not used", {a, d1}, {1'b0, 8'h15});
    line_sel = 17;
    run_line(17, mk_pkt(8'h31, 8'h32), 23, a, b);
    ck_eq("R2 low edge", {d1, d2, a}, {16'h3132, 1'b1});
    pulse(rd2); pulse(ack);
    line_sel = 23;
    run_line(23, mk_pkt(8'h8A, 8'h4C), 23, a, b);
    ck_eq("R2 high edge", {d1, d2, a}, {16'h8A4C, 1'b1});
    pulse(rd2); pulse(ack);
  endtask

  task automatic t_no_start();
    logic a, b;
    run_line(23, 32'hFFFF_FFFF, 23, a, b);
    ck_eq("R3 no pattern no load", {d1, d2, nd}, {16'h8A4C, 1'b0});
    ck_eq("R7 irq anyway", a, 1);
    pulse(ack);
  endtask

  task automatic t_extra_bits();
    logic a, b;
    run_line(23, mk_pkt(8'h62, 8'h52) | 32'h0780_0000, 27, a, b);
    ck_eq("R4 extra bits ignored", {d1, d2}, 16'h6252);
    ck_eq("R3 run-in not stored", nd, 1);
    pulse(rd2); pulse(ack);
  endtask

  initial begin
    #3000000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1 t_reset();
    #24 rst_n = 1;
    t_basic();
    t_parity();
    t_short();
    t_other_line();
    t_clamp();
    t_no_start();
    t_extra_bits();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule